// File: doc/BRIEF.md
# Dual-Mode Conversion Result Serial Port

This block sends a 20-bit conversion result out over a serial line. A new result arrives once per sampling frame on a one-clock strobe and is loaded into an output register. A host selects the port with an active-low chip-select and is told through an active-low ready line when an unread word is waiting. The data line and the clock line each have an output-enable, so the pads around the block can three-state them.

The port has two clocking modes. In self-clocked mode the port makes its own serial clock. It only sends during the computation half of a 1024-clock sampling frame, and it decides at the start of each 64-clock computation slot whether the host has selected it. In host-clocked mode the host drives the serial clock. Bits then move on the host's falling edges, and chip-select can pause a word at any point. Chip-select and the host clock are resynchronised into the master clock domain before use.

Top module: `conv_serial_port`

## Requirements
- R1: After reset, the ready line is high and neither the data output-enable nor the clock output-enable is asserted.
- R2: In self-clocked mode the serial clock is only high during frame positions 512 to 1023. Frame positions count master clocks from reset release, modulo 1024.
- R3: In self-clocked mode the serial clock is high for exactly one master clock out of every four, at frame positions where position mod 4 equals 3.
- R4: A word is sent most-significant bit first. Each bit is stable while the serial clock is high, and the data changes as the serial clock falls.
- R5: In self-clocked mode, if chip-select goes high in the middle of a word, both outputs are released after the current bit. Sending later resumes with the next unsent bit, in a computation slot that begins while chip-select is low.
- R6: The ready line goes high once the least-significant bit has been sent, and stays high until the next load.
- R7: On every load the ready line is high for exactly 4 master clocks and then falls. The next transmission starts again from the most-significant bit, even if the previous word was only partly sent.
- R8: In host-clocked mode, within 4 master clocks of chip-select falling, the most-significant bit is driven on the data line. Each later falling edge of the host clock moves to the next bit.
- R9: In host-clocked mode, chip-select going high releases the data line within 4 master clocks. Host clock edges seen while chip-select is high are ignored. When chip-select falls again, the same bit is presented again.
- R10: In host-clocked mode, a new word that arrives while chip-select is low and the current word is unfinished is discarded. In that case the ready line does not pulse and the word being sent is not changed.
- R11: A chip-select that is low during the 4-clock ready pulse is not acted on until the pulse ends. The data line is then driven in the clock after the pulse.
- R12: In host-clocked mode the clock output-enable is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| extMode | input | 1 | 1 = host-clocked mode, 0 = self-clocked mode |
| newWordStb | input | 1 | One-clock strobe: a new result is available |
| newWord | input | 20 | New result value |
| csN | input | 1 | Active-low chip-select (asynchronous) |
| sclkIn | input | 1 | Host serial clock (asynchronous) |
| sclkOut | output | 1 | Generated serial clock |
| sclkOe | output | 1 | Output-enable for the serial clock pad |
| sdo | output | 1 | Serial data |
| sdoOe | output | 1 | Output-enable for the serial data pad |
| rdyN | output | 1 | Active-low data-ready |

## Verification
The hardest case to reach from the ports is a word in self-clocked mode that is split across several computation slots because chip-select was raised partway through. A reload that lands on such a partly sent word is just as hard. The stimulus drives chip-select at known frame positions, counted from reset release. It raises chip-select a few bits into slot 8 and lowers it again before slot 11. It then checks that the collected bits still form the original word. A second pass leaves a word half-sent and strobes a fresh one in the next frame. This exposes the 4-clock ready pulse and the restart from the most-significant bit.

// File: rtl/csp_pkg.sv
package csp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new word, restart at MSB
    logic advance;  // move to the next bit
  } csp_strb_t;
endpackage

// File: rtl/csp_ctrl.sv
module csp_ctrl
  import csp_pkg::*;
#(
  parameter int SLOT_LEN  = 64,
  parameter int SLOT_NUM  = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      extMode,
  input  logic      csN,
  input  logic      sclkIn,
  input  logic      newWordStb,
  input  logic      sent,
  input  logic      lastBit,
  output csp_strb_t strb,
  output logic      rdyN,
  output logic      sclkOut,
  output logic      sclkOe,
  output logic      sdoOe
);
  localparam int FRAME_LEN = SLOT_LEN * SLOT_NUM;
  localparam int FCW       = $clog2(FRAME_LEN);
  localparam int SLW       = $clog2(SLOT_LEN);
  localparam int PCW       = $clog2(PULSE_LEN + 1);

  logic csMeta, csSync, sclkMeta, sclkSync, sclkPrev;
  logic [FCW-1:0] frameCnt, nextCnt;
  logic [PCW-1:0] pulseCnt;
  logic active;
  logic csLow, pulseIdle, sclkFall, bitEnd, extOe, selfAdv;
  logic slotStartNext, slotBoundNext;

  // two-flop synchronisers for the asynchronous host inputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csMeta   <= 1'b1;
      csSync   <= 1'b1;
      sclkMeta <= 1'b0;
      sclkSync <= 1'b0;
      sclkPrev <= 1'b0;
    end else begin
      csMeta   <= csN;
      csSync   <= csMeta;
      sclkMeta <= sclkIn;
      sclkSync <= sclkMeta;
      sclkPrev <= sclkSync;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) frameCnt <= '0;
    else       frameCnt <= nextCnt;
  end

  always_comb begin
    nextCnt       = frameCnt + FCW'(1);
    csLow         = !csSync;
    pulseIdle     = (pulseCnt == '0);
    sclkFall      = sclkPrev && !sclkSync;
    bitEnd        = (frameCnt[1:0] == 2'd3);
    slotBoundNext = (nextCnt[SLW-1:0] == '0);
    slotStartNext = slotBoundNext && nextCnt[FCW-1];
    extOe         = extMode && csLow && !sent && pulseIdle;
    selfAdv       = !extMode && active && bitEnd;
    strb.load     = newWordStb && !(extMode && csLow && !sent);
    strb.advance  = selfAdv || (extOe && sclkFall);
  end

  // self-clocked send window, decided at each computation slot start
  always_ff @(posedge clk) begin
    if (!rstN)
      active <= 1'b0;
    else if (extMode || strb.load)
      active <= 1'b0;
    else if (slotStartNext)
      active <= csLow && pulseIdle && !sent && !(selfAdv && lastBit);
    else if (slotBoundNext || (selfAdv && (csSync || lastBit)))
      active <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            pulseCnt <= '0;
    else if (strb.load)   pulseCnt <= PCW'(PULSE_LEN);
    else if (!pulseIdle)  pulseCnt <= pulseCnt - PCW'(1);
  end

  assign rdyN    = sent || !pulseIdle;
  assign sclkOe  = active;
  assign sclkOut = active && bitEnd;
  assign sdoOe   = extMode ? extOe : active;

  a_r3_sclk_single: assert property (@(posedge clk) disable iff (!rstN)
    sclkOut |=> !sclkOut);
  a_r2_compute_only: assert property (@(posedge clk) disable iff (!rstN)
    sclkOe |-> frameCnt[FCW-1]);
  a_r12_ext_no_sclk: assert property (@(posedge clk) disable iff (!rstN)
    extMode |-> !sclkOe);
  a_r11_pulse_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (pulseCnt != '0) |-> !sdoOe);
endmodule

// File: rtl/csp_datapath.sv
module csp_datapath
  import csp_pkg::*;
#(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  csp_strb_t         strb,
  input  logic [WORD_W-1:0] newWord,
  output logic              curBit,
  output logic              lastBit,
  output logic              sent
);
  localparam int IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] wordReg;
  logic [IDX_W-1:0]  bitIdx;

  assign curBit  = wordReg[WORD_W-1];
  assign lastBit = (bitIdx == IDX_W'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReg <= '0;
      bitIdx  <= '0;
      sent    <= 1'b1;
    end else if (strb.load) begin
      wordReg <= newWord;
      bitIdx  <= '0;
      sent    <= 1'b0;
    end else if (strb.advance) begin
      wordReg <= {wordReg[WORD_W-2:0], 1'b0};
      if (lastBit) begin
        sent   <= 1'b1;
        bitIdx <= '0;
      end else begin
        bitIdx <= bitIdx + IDX_W'(1);
      end
    end
  end

  a_r7_restart_msb: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (bitIdx == '0 && !sent));
  a_r6_sent_after_lsb: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.load && lastBit) |=> sent);
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port
  import csp_pkg::*;
#(
  parameter int WORD_W    = 20,
  parameter int SLOT_LEN  = 64,
  parameter int SLOT_NUM  = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extMode,
  input  logic              newWordStb,
  input  logic [WORD_W-1:0] newWord,
  input  logic              csN,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              sclkOe,
  output logic              sdo,
  output logic              sdoOe,
  output logic              rdyN
);
  csp_strb_t strb;
  logic curBit, lastBit, sent;

  csp_ctrl #(
    .SLOT_LEN (SLOT_LEN),
    .SLOT_NUM (SLOT_NUM),
    .PULSE_LEN(PULSE_LEN)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .extMode   (extMode),
    .csN       (csN),
    .sclkIn    (sclkIn),
    .newWordStb(newWordStb),
    .sent      (sent),
    .lastBit   (lastBit),
    .strb      (strb),
    .rdyN      (rdyN),
    .sclkOut   (sclkOut),
    .sclkOe    (sclkOe),
    .sdoOe     (sdoOe)
  );

  csp_datapath #(.WORD_W(WORD_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .newWord(newWord),
    .curBit (curBit),
    .lastBit(lastBit),
    .sent   (sent)
  );

  assign sdo = sdoOe && curBit;
endmodule

// File: tb/conv_serial_port_tb_top.sv
`timescale 1ns/1ps
module conv_serial_port_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extMode = 1'b0;
  logic newWordStb = 1'b0;
  logic [19:0] newWord = '0;
  logic csN = 1'b1;
  logic sclkIn = 1'b0;
  logic sclkOut, sclkOe, sdo, sdoOe, rdyN;

  always #4 clk = ~clk;

  conv_serial_port dut_i (
    .clk(clk), .rstN(rstN), .extMode(extMode), .newWordStb(newWordStb),
    .newWord(newWord), .csN(csN), .sclkIn(sclkIn), .sclkOut(sclkOut),
    .sclkOe(sclkOe), .sdo(sdo), .sdoOe(sdoOe), .rdyN(rdyN)
  );

  int nChk = 0;
  int nFail = 0;
  int sclkViol = 0;
  int capCnt = 0;
  logic [19:0] capWord = '0;
  logic [9:0] pos = '0;
  int cyc = 0;

  // frame position: master clocks since reset release, modulo 1024
  always @(posedge clk) begin
    if (!rstN) pos <= '0;
    else       pos <= pos + 10'd1;
  end

  // self-clocked monitor: capture on every high clock, check its placement
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rstN && !extMode && sclkOut) begin
      capWord = {capWord[18:0], sdo};
      capCnt  = capCnt + 1;
      if (!(pos[9] && pos[1:0] == 2'd3 && sdoOe)) sclkViol = sclkViol + 1;
    end
    if (rstN && extMode && sclkOe) sclkViol = sclkViol + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk = nChk + 1;
    if (!ok) begin
      nFail = nFail + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic mode);
    @(negedge clk);
    rstN = 1'b0; extMode = mode;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitPos(input int p);
    do @(negedge clk); while (pos != 10'(p));
  endtask

  task automatic strobe(input logic [19:0] w);
    newWord = w; newWordStb = 1'b1;
    @(negedge clk);
    newWordStb = 1'b0;
  endtask

  task automatic waitRdy();
    int n = 0;
    while (!rdyN && n < 4000) begin @(negedge clk); n++; end
  endtask

  task automatic hostBit(output logic b);
    b = sdo;
    sclkIn = 1'b1; repeat (4) @(negedge clk);
    sclkIn = 1'b0; repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    while (cyc < 100000) @(negedge clk);
    nChk = nChk + 1; nFail = nFail + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin : stim
    logic [19:0] w1, w2, w4, w5, got;
    logic b;
    w1 = 20'hA5C3E; w2 = 20'h3F0C1; w4 = 20'hC0FFE; w5 = 20'h9B2D4;

    // ---------- self-clocked mode ----------
    doReset(1'b0);
    @(negedge clk);
    chk(rdyN && !sdoOe && !sclkOe, "R1 reset state", {rdyN, sdoOe, sclkOe}, 3'b100);
    csN = 1'b0;
    waitPos(100);
    capCnt = 0;
    strobe(w1);
    repeat (3) @(negedge clk);
    chk(rdyN, "R7 pulse high after load", rdyN, 1);
    @(negedge clk);
    chk(!rdyN, "R7 ready falls after 4 clocks", rdyN, 0);
    waitRdy();
    chk(capCnt == 20 && capWord == w1, "R4 self word MSB first", capWord, w1);
    chk(rdyN && !sdoOe, "R6 ready after LSB", {rdyN, sdoOe}, 2'b10);

    // chip-select raised mid-word, resumed in a later slot (R5)
    waitPos(100);
    capCnt = 0;
    strobe(w2);
    waitPos(520);
    csN = 1'b1;
    waitPos(560);
    chk(!sdoOe && !sclkOe, "R5 released after current bit", {sdoOe, sclkOe}, 0);
    waitPos(700);
    csN = 1'b0;
    waitRdy();
    chk(capCnt == 20 && capWord == w2, "R5 resumed with next bit", capWord, w2);

    // reload on a partly sent word (R7)
    waitPos(100);
    strobe(20'h12345);
    waitPos(530);
    csN = 1'b1;
    waitPos(100);
    capCnt = 0;
    strobe(w4);
    chk(rdyN, "R7 pulse on unfinished word", rdyN, 1);
    repeat (3) @(negedge clk);
    chk(rdyN, "R7 pulse still high at 4th clock", rdyN, 1);
    @(negedge clk);
    chk(!rdyN, "R7 pulse ends", rdyN, 0);
    waitPos(200);
    csN = 1'b0;
    waitRdy();
    chk(capCnt == 20 && capWord == w4, "R7 restart from MSB", capWord, w4);
    chk(sclkViol == 0, "R2 R3 clock only in compute slots, phase 3", sclkViol, 0);

    // ---------- host-clocked mode ----------
    csN = 1'b1;
    doReset(1'b1);
    repeat (2) @(negedge clk);
    strobe(w5);
    repeat (6) @(negedge clk);
    csN = 1'b0;
    repeat (4) @(negedge clk);
    chk(sdoOe && sdo == w5[19], "R8 MSB after chip-select", {sdoOe, sdo}, {1'b1, w5[19]});
    got = '0;
    for (int i = 0; i < 10; i++) begin hostBit(b); got = {got[18:0], b}; end
    csN = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sdoOe, "R9 release on chip-select high", sdoOe, 0);
    sclkIn = 1'b1; repeat (4) @(negedge clk);
    sclkIn = 1'b0; repeat (4) @(negedge clk);
    csN = 1'b0;
    repeat (4) @(negedge clk);
    chk(sdoOe && sdo == w5[9], "R9 same bit resumes", sdo, w5[9]);
    strobe(20'h0F0F0);
    for (int i = 0; i < 5; i++) begin
      chk(!rdyN, "R10 no pulse on discarded word", rdyN, 0);
      @(negedge clk);
    end
    for (int i = 0; i < 10; i++) begin hostBit(b); got = {got[18:0], b}; end
    chk(got == w5, "R10 R8 original word sent", got, w5);
    chk(rdyN && !sdoOe, "R6 ready after LSB host mode", {rdyN, sdoOe}, 2'b10);

    // chip-select held low across a load (R11)
    strobe(20'h5A5A5);
    chk(!sdoOe, "R11 blocked in pulse clock 1", sdoOe, 0);
    repeat (3) @(negedge clk);
    chk(!sdoOe && rdyN, "R11 blocked in pulse clock 4", {sdoOe, rdyN}, 2'b01);
    @(negedge clk);
    chk(sdoOe && sdo == 1'b0 && !rdyN, "R11 drive after pulse", {sdoOe, sdo, rdyN}, 3'b100);
    chk(sclkViol == 0, "R12 no clock enable in host mode", sclkViol, 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule